// File: doc/BRIEF.md
# Posterior RAM Bypass Controller

This block sequences the accesses to the posterior log-likelihood RAM of a pipelined, layer-by-layer LDPC decoder. Software loads two ordered column lists for each layer. The read list sets the order in which columns enter the pipeline. The write-back list sets the order in which updated values leave the adder. Each entry carries a bypass flag. A bypass entry of a write-back list marks a column that the next layer also uses. In that cycle the adder result is not stored. The matching bypass entry at the head of the next layer's read list takes the value straight from the adder through an input mux. This saves one RAM write and one RAM read.

Reads and write-backs run as two engines. Write-backs of a layer start a fixed number of cycles after that layer's last read. The read engine of the next layer proceeds at the same time and stalls one cycle at a time when a dependency is not yet met. Two counters record the RAM accesses made and the accesses saved.

Top module: `posterior_bypass_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `stall`, both RAM strobes, `fwd_sel` and both counters are 0.
- R2: Within a layer, columns are issued in read-list order, at most one per cycle. Write-backs follow write-list order, one per cycle. The first write-back comes LAT (default 2) cycles after the cycle in which that layer's last column was issued.
- R3: A bypass read entry of a layer other than the first is issued only in the cycle when the write side presents a bypass write entry of the previous layer with the same column. In that cycle `fwd_sel` is 1 and neither RAM strobe is raised for that column.
- R4: While a bypass read entry waits for its forwarded value, `stall` is 1 and no RAM read, forward or issue takes place. A stale RAM read is never used as a fallback.
- R5: Bypass flags in the first layer's read list and in the last layer's write list are ignored. Those entries use a normal RAM read or a normal RAM write.
- R6: A non-bypass read of a column that still has a RAM write pending from the previous layer stalls. This holds even in the cycle of that write. The read is issued one cycle after the write.
- R7: The write side holds one layer at a time. A layer's last read is issued only when the write side is idle or is making its final write-back.
- R8: `acc_cnt` adds one per RAM read strobe and one per RAM write strobe. `save_cnt` adds one per forwarded read and one per suppressed write. Both saturate at 2^CNT_W-1 and read 0 in the cycle after `start`.
- R9: `done` pulses for one cycle, in the cycle after the final write-back of the last layer. `busy` is 0 in that cycle.
- R10: Take three layers of four columns each, where each adjacent pair of layers shares three columns and all shared columns carry the bypass flag. This run ends with 12 RAM accesses and 12 saved accesses, half of the 24 a non-bypassing run needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Writes one list entry |
| cfg_wlist | input | 1 | Selects the list: 0 read list, 1 write-back list |
| cfg_layer | input | 3 | Layer index for an entry or a length |
| cfg_slot | input | 4 | Position inside the list |
| cfg_col | input | 4 | Block column index of the entry |
| cfg_byp | input | 1 | Bypass flag of the entry |
| cfg_len_we | input | 1 | Writes the entry count of `cfg_layer` |
| cfg_len | input | 5 | Entries in that layer, 1 to 16 |
| num_layers | input | 4 | Layers per run, 1 to 8, captured at `start` |
| start | input | 1 | Begins a run and clears the counters |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_addr | output | 4 | RAM read column (0 when idle) |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | 4 | RAM write column (0 when idle) |
| fwd_sel | output | 1 | Input mux takes the adder value |
| issue_valid | output | 1 | A column enters the pipeline |
| issue_col | output | 4 | Column at the read position |
| wb_valid | output | 1 | The adder presents an updated value |
| wb_col | output | 4 | Column of that value |
| stall | output | 1 | Idle cycle inserted on the read side |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| acc_cnt | output | 16 | RAM accesses made |
| save_cnt | output | 16 | RAM accesses avoided |

## Verification
The cycle-exact main pattern is a three-layer chain with three shared columns per boundary and bypass flags set everywhere possible. It separates correct forward alignment from early forwarding and from stale RAM fallback. It also exercises the flags that must be ignored on the first and last layers. A pattern with a shared column and no bypass flag shows whether the read waits past the pending RAM write rather than reading in the same cycle. A pattern with a long write-back followed by a one-column layer shows whether the write side is overrun. A run of many non-bypass layers drives the access counter into saturation, and a restart shows that the counters clear.

// File: rtl/posterior_bypass_ctrl.sv
module posterior_bypass_ctrl #(
  parameter int LAYERS = 8,
  parameter int SLOTS  = 16,
  parameter int COL_W  = 4,
  parameter int LAT    = 2,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic                         cfg_wlist,
  input  logic [$clog2(LAYERS)-1:0]    cfg_layer,
  input  logic [$clog2(SLOTS)-1:0]     cfg_slot,
  input  logic [COL_W-1:0]             cfg_col,
  input  logic                         cfg_byp,
  input  logic                         cfg_len_we,
  input  logic [$clog2(SLOTS+1)-1:0]   cfg_len,
  input  logic [$clog2(LAYERS):0]      num_layers,
  input  logic                         start,
  output logic                         ram_rd_en,
  output logic [COL_W-1:0]             ram_rd_addr,
  output logic                         ram_wr_en,
  output logic [COL_W-1:0]             ram_wr_addr,
  output logic                         fwd_sel,
  output logic                         issue_valid,
  output logic [COL_W-1:0]             issue_col,
  output logic                         wb_valid,
  output logic [COL_W-1:0]             wb_col,
  output logic                         stall,
  output logic                         busy,
  output logic                         done,
  output logic [CNT_W-1:0]             acc_cnt,
  output logic [CNT_W-1:0]             save_cnt
);

  localparam int LW    = $clog2(LAYERS);
  localparam int SW    = $clog2(SLOTS);
  localparam int LEN_W = $clog2(SLOTS+1);
  localparam int IDX_W = $clog2(LAYERS*SLOTS);
  localparam int DLY_W = $clog2(LAT+1);
  localparam int ENT   = LAYERS*SLOTS;

  logic [COL_W-1:0] rcol_m [ENT];
  logic             rbyp_m [ENT];
  logic [COL_W-1:0] wcol_m [ENT];
  logic             wbyp_m [ENT];
  logic [LEN_W-1:0] len_m  [LAYERS];

  logic [IDX_W-1:0] cfg_idx;
  assign cfg_idx = IDX_W'(cfg_layer) * IDX_W'(SLOTS) + IDX_W'(cfg_slot);

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_wlist) begin
      rcol_m[cfg_idx] <= cfg_col;
      rbyp_m[cfg_idx] <= cfg_byp;
    end
    if (cfg_we && cfg_wlist) begin
      wcol_m[cfg_idx] <= cfg_col;
      wbyp_m[cfg_idx] <= cfg_byp;
    end
    if (cfg_len_we) len_m[cfg_layer] <= cfg_len;
  end

  logic          ract, wact;
  logic [LW-1:0] rl, wl;
  logic [SW-1:0] rs, wp;
  logic [DLY_W-1:0] wdly;
  logic [LW:0]   nl_q;

  logic [IDX_W-1:0] r_idx, w_base, w_idx;
  logic [COL_W-1:0] r_col, w_col;
  logic r_byp, r_last, r_final, w_final, w_byp, w_go, w_last, w_free;
  logic fwd_ok, pend_hit, r_ok, issue;

  assign r_idx   = IDX_W'(rl) * IDX_W'(SLOTS) + IDX_W'(rs);
  assign r_col   = rcol_m[r_idx];
  assign r_byp   = rbyp_m[r_idx] && (rl != '0);
  assign r_last  = (LEN_W'(rs) + LEN_W'(1)) == len_m[rl];
  assign r_final = ((LW+1)'(rl) + (LW+1)'(1)) == nl_q;

  assign w_base  = IDX_W'(wl) * IDX_W'(SLOTS);
  assign w_idx   = w_base + IDX_W'(wp);
  assign w_col   = wcol_m[w_idx];
  assign w_final = ((LW+1)'(wl) + (LW+1)'(1)) == nl_q;
  assign w_byp   = wbyp_m[w_idx] && !w_final;
  assign w_go    = wact && (wdly == '0);
  assign w_last  = (LEN_W'(wp) + LEN_W'(1)) == len_m[wl];
  assign w_free  = !wact || (w_go && w_last);

  assign fwd_ok  = w_go && w_byp && (w_col == r_col);

  always_comb begin
    pend_hit = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (wact && (SW'(s) >= wp) && (LEN_W'(s) < len_m[wl]) &&
          !(wbyp_m[w_base + IDX_W'(s)] && !w_final) &&
          (wcol_m[w_base + IDX_W'(s)] == r_col))
        pend_hit = 1'b1;
    end
  end

  assign r_ok  = r_byp ? fwd_ok : !pend_hit;
  assign issue = ract && r_ok && (!r_last || w_free);

  assign stall       = ract && !issue;
  assign issue_valid = issue;
  assign issue_col   = r_col;
  assign fwd_sel     = issue && r_byp;
  assign ram_rd_en   = issue && !r_byp;
  assign ram_rd_addr = ram_rd_en ? r_col : '0;
  assign wb_valid    = w_go;
  assign wb_col      = w_col;
  assign ram_wr_en   = w_go && !w_byp;
  assign ram_wr_addr = ram_wr_en ? w_col : '0;
  assign busy        = ract || wact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ract <= 1'b0;
      rl   <= '0;
      rs   <= '0;
      nl_q <= '0;
    end else if (start) begin
      ract <= 1'b1;
      rl   <= '0;
      rs   <= '0;
      nl_q <= num_layers;
    end else if (issue) begin
      if (r_last) begin
        rs <= '0;
        if (r_final) ract <= 1'b0;
        else         rl   <= rl + LW'(1);
      end else begin
        rs <= rs + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact <= 1'b0;
      wl   <= '0;
      wp   <= '0;
      wdly <= '0;
      done <= 1'b0;
    end else begin
      done <= !start && w_go && w_last && w_final;
      if (start) begin
        wact <= 1'b0;
      end else if (issue && r_last) begin
        wact <= 1'b1;
        wl   <= rl;
        wp   <= '0;
        wdly <= DLY_W'(LAT-1);
      end else if (w_go) begin
        if (w_last) wact <= 1'b0;
        else        wp   <= wp + SW'(1);
      end else if (wact) begin
        wdly <= wdly - DLY_W'(1);
      end
    end
  end

  logic [CNT_W:0] acc_sum, save_sum;
  assign acc_sum  = {1'b0, acc_cnt}  + (CNT_W+1)'(ram_rd_en) + (CNT_W+1)'(ram_wr_en);
  assign save_sum = {1'b0, save_cnt} + (CNT_W+1)'(fwd_sel)   + (CNT_W+1)'(w_go && w_byp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      save_cnt <= '0;
    end else if (start) begin
      acc_cnt  <= '0;
      save_cnt <= '0;
    end else begin
      acc_cnt  <= acc_sum[CNT_W]  ? '1 : acc_sum[CNT_W-1:0];
      save_cnt <= save_sum[CNT_W] ? '1 : save_sum[CNT_W-1:0];
    end
  end

  p_fwd_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_sel |-> (wb_valid && !ram_wr_en && !ram_rd_en && wb_col == issue_col));

  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!ram_rd_en && !fwd_sel && !issue_valid));

  p_no_rw_collision_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd_en && ram_wr_en && ram_rd_addr == ram_wr_addr));

  p_clear_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_cnt == '0 && save_cnt == '0));

  p_count_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (acc_cnt >= $past(acc_cnt) && save_cnt >= $past(save_cnt)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/posterior_bypass_ctrl_tb.sv
`timescale 1ns/1ps
module posterior_bypass_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_wlist = 1'b0, cfg_byp = 1'b0, cfg_len_we = 1'b0, start = 1'b0;
  logic [2:0] cfg_layer = '0;
  logic [3:0] cfg_slot = '0, cfg_col = '0;
  logic [4:0] cfg_len = '0;
  logic [3:0] num_layers = '0;
  logic ram_rd_en, ram_wr_en, fwd_sel, issue_valid, wb_valid, stall, busy, done;
  logic [3:0] ram_rd_addr, ram_wr_addr, issue_col, wb_col;
  logic [4:0] acc_cnt, save_cnt;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  posterior_bypass_ctrl #(.CNT_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wlist(cfg_wlist),
    .cfg_layer(cfg_layer), .cfg_slot(cfg_slot), .cfg_col(cfg_col), .cfg_byp(cfg_byp),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .num_layers(num_layers), .start(start),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_wr_en(ram_wr_en),
    .ram_wr_addr(ram_wr_addr), .fwd_sel(fwd_sel), .issue_valid(issue_valid),
    .issue_col(issue_col), .wb_valid(wb_valid), .wb_col(wb_col), .stall(stall),
    .busy(busy), .done(done), .acc_cnt(acc_cnt), .save_cnt(save_cnt));

  // {rd_en, rd_addr, fwd, wr_en, wr_addr, stall} for cycles 1..21 of the chain run
  localparam logic [11:0] CHAIN [21] = '{
    {1'b1,4'd3,1'b0,1'b0,4'd0,1'b0}, {1'b1,4'd0,1'b0,1'b0,4'd0,1'b0},
    {1'b1,4'd1,1'b0,1'b0,4'd0,1'b0}, {1'b1,4'd2,1'b0,1'b0,4'd0,1'b0},
    {1'b0,4'd0,1'b0,1'b0,4'd0,1'b1}, {1'b0,4'd0,1'b0,1'b1,4'd3,1'b1},
    {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0}, {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0},
    {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0}, {1'b1,4'd4,1'b0,1'b0,4'd0,1'b0},
    {1'b0,4'd0,1'b0,1'b0,4'd0,1'b1}, {1'b0,4'd0,1'b0,1'b1,4'd4,1'b1},
    {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0}, {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0},
    {1'b0,4'd0,1'b1,1'b0,4'd0,1'b0}, {1'b1,4'd5,1'b0,1'b0,4'd0,1'b0},
    {1'b0,4'd0,1'b0,1'b0,4'd0,1'b0}, {1'b0,4'd0,1'b0,1'b1,4'd5,1'b0},
    {1'b0,4'd0,1'b0,1'b1,4'd0,1'b0}, {1'b0,4'd0,1'b0,1'b1,4'd1,1'b0},
    {1'b0,4'd0,1'b0,1'b1,4'd2,1'b0}};

  logic [11:0] cap_v  [1:64];
  logic        cap_dn [1:64];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic wl, input int layer, input int slot, input int col, input logic byp);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wlist = wl; cfg_layer = 3'(layer); cfg_slot = 4'(slot);
    cfg_col = 4'(col); cfg_byp = byp;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_len(input int layer, input int n);
    @(negedge clk);
    cfg_len_we = 1'b1; cfg_layer = 3'(layer); cfg_len = 5'(n);
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic run_capture(input int n, input int nl);
    @(negedge clk);
    num_layers = 4'(nl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= n; c++) begin
      if (c > 1) @(negedge clk);
      cap_v[c]  = {ram_rd_en, ram_rd_addr, fwd_sel, ram_wr_en, ram_wr_addr, stall};
      cap_dn[c] = done;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {ram_rd_en, ram_wr_en, fwd_sel, stall}, 0);
    chk("R1 acc_cnt", acc_cnt, 0);
    chk("R1 save_cnt", save_cnt, 0);

    // chain: layer0 {3,0,1,2}, layer1 {0,1,2,4}, layer2 {0,1,2,5}; shared columns 0,1,2
    put(0,0,0,3,0); put(0,0,1,0,1); put(0,0,2,1,1); put(0,0,3,2,1);
    put(1,0,0,3,0); put(1,0,1,0,1); put(1,0,2,1,1); put(1,0,3,2,1);
    put(0,1,0,0,1); put(0,1,1,1,1); put(0,1,2,2,1); put(0,1,3,4,0);
    put(1,1,0,4,0); put(1,1,1,0,1); put(1,1,2,1,1); put(1,1,3,2,1);
    put(0,2,0,0,1); put(0,2,1,1,1); put(0,2,2,2,1); put(0,2,3,5,0);
    put(1,2,0,5,0); put(1,2,1,0,1); put(1,2,2,1,1); put(1,2,3,2,1);
    put_len(0,4); put_len(1,4); put_len(2,4);
    run_capture(22, 3);
    for (int c = 1; c <= 21; c++)
      chk($sformatf("R2 R3 R4 R5 chain cycle %0d", c), cap_v[c], CHAIN[c-1]);
    chk("R9 done after last write", cap_dn[22], 1);
    chk("R9 no early done", cap_dn[21], 0);
    @(negedge clk);
    chk("R10 acc_cnt", acc_cnt, 12);
    chk("R10 save_cnt", save_cnt, 12);
    chk("R9 done is one pulse", done, 0);

    // R6: column 1 shared without bypass flag
    put(0,0,0,1,0); put(0,0,1,2,0); put(1,0,0,2,0); put(1,0,1,1,0);
    put(0,1,0,1,0); put(0,1,1,3,0); put(1,1,0,1,0); put(1,1,1,3,0);
    put_len(0,2); put_len(1,2);
    run_capture(12, 2);
    chk("R6 first read", cap_v[1], {1'b1,4'd1,1'b0,1'b0,4'd0,1'b0});
    chk("R6 stall before write", cap_v[3], {1'b0,4'd0,1'b0,1'b0,4'd0,1'b1});
    chk("R6 stall other write", cap_v[4], {1'b0,4'd0,1'b0,1'b1,4'd2,1'b1});
    chk("R6 stall in write cycle", cap_v[5], {1'b0,4'd0,1'b0,1'b1,4'd1,1'b1});
    chk("R6 read after write", cap_v[6], {1'b1,4'd1,1'b0,1'b0,4'd0,1'b0});
    chk("R6 next read", cap_v[7], {1'b1,4'd3,1'b0,1'b0,4'd0,1'b0});
    chk("R6 done", cap_dn[11], 1);
    @(negedge clk);

    // R7: long write-back followed by a one-column layer
    put(0,0,0,1,0); put(0,0,1,2,0); put(0,0,2,3,0);
    put(1,0,0,1,0); put(1,0,1,2,0); put(1,0,2,3,0);
    put(0,1,0,4,0); put(1,1,0,4,0);
    put_len(0,3); put_len(1,1);
    run_capture(12, 2);
    chk("R7 wait idle side", cap_v[4], {1'b0,4'd0,1'b0,1'b0,4'd0,1'b1});
    chk("R7 wait mid write", cap_v[5], {1'b0,4'd0,1'b0,1'b1,4'd1,1'b1});
    chk("R7 wait second write", cap_v[6], {1'b0,4'd0,1'b0,1'b1,4'd2,1'b1});
    chk("R7 issue on final write", cap_v[7], {1'b1,4'd4,1'b0,1'b1,4'd3,1'b0});
    chk("R2 write delay", cap_v[9], {1'b0,4'd0,1'b0,1'b1,4'd4,1'b0});
    chk("R9 done", cap_dn[10], 1);
    @(negedge clk);

    // R8: saturation with three full non-bypass layers
    for (int l = 0; l < 3; l++) begin
      for (int s = 0; s < 16; s++) begin
        put(0,l,s,s,0);
        put(1,l,s,s,0);
      end
      put_len(l,16);
    end
    run_capture(2, 3);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R8 acc saturates", acc_cnt, 31);
    chk("R8 save stays zero", save_cnt, 0);
    run_capture(1, 3);
    chk("R8 clear on start acc", acc_cnt, 0);
    chk("R8 clear on start save", save_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule